// File: doc/BRIEF.md
# Multi-Format Pixel Unpacker

The unpacker sits between a frame-buffer word fetcher and a display output stage. It takes 32-bit memory words through a valid/ready handshake and produces one 24-bit RGB pixel on each cycle in which the pixel-clock enable is high. Four source formats are supported: packed 24-bit colour with three words holding four pixels, 16-bit 5-6-5 colour, 8-bit grayscale, and 8-bit palette indices. Palette indices are resolved through an external colour table reached by a request/acknowledge port.

Source bits are used strictly in order, most significant bit first. Any bits left over from one word are carried over and placed in front of the next word. The format is picked up only while video output is switched off. Switching off also throws away buffered bits and any lookup that is still pending, so a new format always starts on a word boundary.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset, `pix_rgb` is 0, `pix_underrun` is 0, `lut_req` is 0, and `word_ready` is 0 until `video_en` is high.
- R2: While `video_en` is low, the format is latched from `cfg_depth`/`cfg_pseudo`, buffered bits are discarded, a pending lookup is dropped, and `pix_rgb` and `pix_underrun` read 0. Changes to the configuration inputs while `video_en` is high have no effect on the output.
- R3: With `cfg_depth[1]`=1 (24-bit), words w0,w1,w2 give pixels w0[31:8], {w0[7:0],w1[31:16]}, {w1[15:0],w2[31:24]}, w2[23:0], in that order.
- R4: With `cfg_depth`=0 and `cfg_pseudo`=0 (grayscale), each byte is taken starting at bits 31:24, and the pixel is that byte copied into red, green and blue.
- R5: With `cfg_depth`=0 and `cfg_pseudo`=1 (palette), each byte is taken most significant first and appears on `lut_idx` with `lut_req` high. `lut_req` stays high until `lut_ack`. In the cycle after the acknowledge, `pix_rgb` equals `lut_entry[23:0]`. No word is accepted while the request is open.
- R6: With `cfg_depth`=1 (16-bit), the upper halfword c is used first, and the output is {c[15:11],3'b0,c[10:5],2'b0,c[4:0],3'b0}.
- R7: `word_ready` is high exactly when `video_en` and `pix_en` are high, no lookup is pending, and fewer buffered bits remain than one pixel needs. A word is taken when `word_valid` and `word_ready` are both high.
- R8: If `pix_en` finds too few buffered bits and no valid word, `pix_underrun` rises, `pix_rgb` holds its value and nothing is consumed. The flag clears when the next pixel is produced.
- R9: Pixel output is red in bits 23:16, green in 15:8 and blue in 7:0, and it updates one cycle after the enable that produces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| video_en | input | 1 | Output enable; low to load the format |
| cfg_depth | input | 2 | Colour depth select |
| cfg_pseudo | input | 1 | Palette select for 8-bit depth |
| pix_en | input | 1 | Pixel-clock enable |
| word_valid | input | 1 | Source word present |
| word_data | input | 32 | Source word |
| word_ready | output | 1 | Source word taken this cycle when valid |
| lut_req | output | 1 | Colour lookup outstanding |
| lut_idx | output | 8 | Colour table index |
| lut_ack | input | 1 | Lookup response strobe |
| lut_entry | input | 32 | Lookup response; low 24 bits used |
| pix_rgb | output | 24 | Current pixel |
| pix_underrun | output | 1 | Last pixel request found no data |

## Verification
The assertions assume that the colour table acknowledges only while a request is open and returns exactly one acknowledge per request. The bench keeps to this by driving `lut_ack` only in cycles where its own model has an open request. Format changes while enabled, missing words and stalled lookups are all applied at random, because the block has to tolerate them. Reset is applied once, at the start.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
    parameter int WORD_W = 32;
    parameter int PIX_W  = 24;
    parameter int IDX_W  = 8;
    localparam int BUF_W = WORD_W + PIX_W;
    localparam int CNT_W = $clog2(BUF_W + 1);

    typedef enum logic [1:0] {
        FMT_GRAY = 2'd0,
        FMT_PAL  = 2'd1,
        FMT_565  = 2'd2,
        FMT_RGB  = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [BUF_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        fmt_e             fmt;
        logic             lut_wait;
        logic [IDX_W-1:0] idx;
        logic [PIX_W-1:0] rgb;
        logic             und;
    } pxu_state_t;
endpackage

// File: rtl/pxu_mode_decode.sv
module pxu_mode_decode
    import pxu_pkg::*;
(
    input  logic [1:0]       depth,
    input  logic             pseudo,
    input  fmt_e             cur_fmt,
    output fmt_e             new_fmt,
    output logic [CNT_W-1:0] pix_bits
);
    always_comb begin
        if (depth[1])      new_fmt = FMT_RGB;
        else if (depth[0]) new_fmt = FMT_565;
        else if (pseudo)   new_fmt = FMT_PAL;
        else               new_fmt = FMT_GRAY;
    end

    always_comb begin
        case (cur_fmt)
            FMT_RGB: pix_bits = CNT_W'(PIX_W);
            FMT_565: pix_bits = CNT_W'(16);
            default: pix_bits = CNT_W'(IDX_W);
        endcase
    end
endmodule

// File: rtl/pxu_expand.sv
module pxu_expand
    import pxu_pkg::*;
(
    input  fmt_e             fmt,
    input  logic [PIX_W-1:0] raw,
    output logic [PIX_W-1:0] rgb
);
    logic [15:0] c16;
    logic [7:0]  g8;

    assign c16 = raw[PIX_W-1 -: 16];
    assign g8  = raw[PIX_W-1 -: 8];

    always_comb begin
        case (fmt)
            FMT_RGB: rgb = raw;
            FMT_565: rgb = {c16[15:11], 3'b000, c16[10:5], 2'b00, c16[4:0], 3'b000};
            default: rgb = {g8, g8, g8};
        endcase
    end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              video_en,
    input  logic [1:0]        cfg_depth,
    input  logic              cfg_pseudo,
    input  logic              pix_en,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              lut_req,
    output logic [IDX_W-1:0]  lut_idx,
    input  logic              lut_ack,
    input  logic [WORD_W-1:0] lut_entry,
    output logic [PIX_W-1:0]  pix_rgb,
    output logic              pix_underrun
);
    pxu_state_t       s_d, s_q;
    fmt_e             cfg_fmt;
    logic [CNT_W-1:0] pix_bits;
    logic             need_word;
    logic [BUF_W-1:0] merged, src;
    logic [PIX_W-1:0] raw_bits, exp_rgb;

    pxu_mode_decode u_dec (
        .depth    (cfg_depth),
        .pseudo   (cfg_pseudo),
        .cur_fmt  (s_q.fmt),
        .new_fmt  (cfg_fmt),
        .pix_bits (pix_bits)
    );

    pxu_expand u_exp (
        .fmt (s_q.fmt),
        .raw (raw_bits),
        .rgb (exp_rgb)
    );

    assign need_word  = s_q.cnt < pix_bits;
    assign merged     = s_q.acc | ({word_data, {PIX_W{1'b0}}} >> s_q.cnt);
    assign src        = need_word ? merged : s_q.acc;
    assign raw_bits   = src[BUF_W-1 -: PIX_W];
    assign word_ready = video_en && pix_en && !s_q.lut_wait && need_word;

    always_comb begin
        s_d = s_q;
        if (!video_en) begin
            s_d.fmt      = cfg_fmt;
            s_d.acc      = '0;
            s_d.cnt      = '0;
            s_d.lut_wait = 1'b0;
            s_d.rgb      = '0;
            s_d.und      = 1'b0;
        end else if (s_q.lut_wait) begin
            if (lut_ack) begin
                s_d.rgb      = lut_entry[PIX_W-1:0];
                s_d.lut_wait = 1'b0;
            end
        end else if (pix_en) begin
            if (need_word && !word_valid) begin
                s_d.und = 1'b1;
            end else begin
                s_d.und = 1'b0;
                s_d.acc = src << pix_bits;
                s_d.cnt = s_q.cnt + (need_word ? CNT_W'(WORD_W) : CNT_W'(0)) - pix_bits;
                if (s_q.fmt == FMT_PAL) begin
                    s_d.lut_wait = 1'b1;
                    s_d.idx      = raw_bits[PIX_W-1 -: IDX_W];
                end else begin
                    s_d.rgb = exp_rgb;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{acc: '0, cnt: '0, fmt: FMT_GRAY, lut_wait: 1'b0,
                     idx: '0, rgb: '0, und: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign lut_req      = s_q.lut_wait;
    assign lut_idx      = s_q.idx;
    assign pix_rgb      = s_q.rgb;
    assign pix_underrun = s_q.und;
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker
    import pxu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             video_en,
    input logic             pix_en,
    input logic             word_ready,
    input logic             lut_req,
    input logic             lut_ack,
    input logic [PIX_W-1:0] pix_rgb,
    input logic             pix_underrun
);
    p_ready_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> (video_en && pix_en));

    p_no_word_in_lookup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lut_req |-> !word_ready);

    p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lut_req && !lut_ack && video_en) |=> lut_req);

    p_ack_in_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lut_ack |-> lut_req);

    p_disabled_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !video_en |=> (!lut_req && !pix_underrun && pix_rgb == '0));

    p_underrun_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_underrun) |-> $stable(pix_rgb));
endmodule

bind pixel_unpacker pxu_checker u_pxu_checker (.*);

// File: tb/pixel_unpacker_test.sv
module pixel_unpacker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        video_en = 1'b0, cfg_pseudo = 1'b0, pix_en = 1'b0;
    logic        word_valid = 1'b0, lut_ack = 1'b0;
    logic [1:0]  cfg_depth = 2'd0;
    logic [31:0] word_data = '0, lut_entry = '0;
    logic        word_ready, lut_req, pix_underrun;
    logic [7:0]  lut_idx;
    logic [23:0] pix_rgb;

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    bit          q[$];
    int          m_fmt = 0;
    logic        m_wait = 0, m_und = 0;
    logic [7:0]  m_idx = '0;
    logic [23:0] m_rgb = '0;

    always #4 clk = ~clk;

    pixel_unpacker uut (.*);

    function automatic int wid(int f);
        return (f == 3) ? 24 : (f == 2) ? 16 : 8;
    endfunction

    function automatic string ftag(int f);
        case (f)
            3: return "R3";
            2: return "R6";
            1: return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(logic en, logic pe, logic wv, logic [31:0] wd,
                        logic [1:0] dp, logic ps, logic ack, logic [31:0] ent);
        bit exp_rdy;
        logic [23:0] v;
        int w;
        video_en = en; pix_en = pe; word_valid = wv; word_data = wd;
        cfg_depth = dp; cfg_pseudo = ps; lut_ack = ack; lut_entry = ent;
        #1;
        w = wid(m_fmt);
        exp_rdy = en && pe && !m_wait && (q.size() < w);
        chk("R7 ready", 32'(word_ready), 32'(exp_rdy));
        if (!en) begin
            m_fmt = dp[1] ? 3 : dp[0] ? 2 : ps ? 1 : 0;
            q.delete(); m_wait = 0; m_rgb = '0; m_und = 0;
        end else if (m_wait) begin
            if (ack) begin m_rgb = ent[23:0]; m_wait = 0; end
        end else if (pe) begin
            if (q.size() < w && !wv) m_und = 1;
            else begin
                if (q.size() < w) for (int i = 31; i >= 0; i--) q.push_back(wd[i]);
                v = '0;
                for (int i = 0; i < w; i++) v = {v[22:0], q.pop_front()};
                m_und = 0;
                if (m_fmt == 1) begin m_wait = 1; m_idx = v[7:0]; end
                else if (m_fmt == 3) m_rgb = v;
                else if (m_fmt == 2) m_rgb = {v[15:11], 3'b0, v[10:5], 2'b0, v[4:0], 3'b0};
                else m_rgb = {v[7:0], v[7:0], v[7:0]};
            end
        end
        @(posedge clk); #2;
        chk({ftag(m_fmt), " R9 rgb"}, 32'(pix_rgb), 32'(m_rgb));
        chk("R8 underrun", 32'(pix_underrun), 32'(m_und));
        chk("R5 req", 32'(lut_req), 32'(m_wait));
        if (m_wait) chk("R5 idx", 32'(lut_idx), 32'(m_idx));
    endtask

    task automatic quiet(logic [1:0] dp, logic ps);
        step(0, 0, 0, '0, dp, ps, 0, '0);
        step(0, 0, 0, '0, dp, ps, 0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 rgb", 32'(pix_rgb), 0);
        chk("R1 underrun", 32'(pix_underrun), 0);
        chk("R1 req", 32'(lut_req), 0);
        chk("R1 ready", 32'(word_ready), 0);
        rst_n = 1'b1;

        // R3: 24-bit packing across three words
        quiet(2'd2, 0);
        step(1, 1, 1, 32'h11223344, 2'd0, 1, 0, '0); chk("R3 p0", 32'(pix_rgb), 32'h112233);
        step(1, 1, 1, 32'h55667788, 2'd0, 1, 0, '0); chk("R3 p1", 32'(pix_rgb), 32'h445566);
        step(1, 1, 1, 32'h99AABBCC, 2'd1, 0, 0, '0); chk("R3 p2", 32'(pix_rgb), 32'h778899);
        step(1, 1, 0, '0, 2'd0, 0, 0, '0);          chk("R3 p3", 32'(pix_rgb), 32'hAABBCC);
        // R8: starvation holds the pixel
        step(1, 1, 0, '0, 2'd0, 0, 0, '0);
        chk("R8 flag", 32'(pix_underrun), 1);
        chk("R8 hold", 32'(pix_rgb), 32'hAABBCC);
        // R4: grayscale
        quiet(2'd0, 0);
        chk("R2 cleared", 32'(pix_rgb), 0);
        step(1, 1, 1, 32'hA1B2C3D4, 2'd2, 0, 0, '0); chk("R4 b0", 32'(pix_rgb), 32'hA1A1A1);
        step(1, 1, 0, '0, 2'd2, 0, 0, '0);          chk("R4 b1", 32'(pix_rgb), 32'hB2B2B2);
        // R6: 5-6-5 expansion
        quiet(2'd1, 0);
        step(1, 1, 1, 32'hF81F07E0, 2'd0, 0, 0, '0); chk("R6 hi", 32'(pix_rgb), 32'hF800F8);
        step(1, 1, 0, '0, 2'd0, 0, 0, '0);          chk("R6 lo", 32'(pix_rgb), 32'h00FC00);
        // R5: palette lookup stall
        quiet(2'd0, 1);
        step(1, 1, 1, 32'h3C000000, 2'd0, 1, 0, '0);
        chk("R5 idx", 32'(lut_idx), 32'h3C);
        step(1, 1, 1, 32'h0, 2'd0, 1, 0, '0);
        chk("R5 stall", 32'(lut_req), 1);
        step(1, 0, 0, '0, 2'd0, 1, 1, 32'hFF123456);
        chk("R5 entry", 32'(pix_rgb), 32'h123456);

        // random traffic; configuration also toggled while enabled (R2)
        for (int seg = 0; seg < 40; seg++) begin
            logic [1:0] dp;
            logic ps;
            dp = 2'($urandom); ps = 1'($urandom);
            quiet(dp, ps);
            for (int c = 0; c < 150; c++)
                step(1, ($urandom % 4) != 0, ($urandom % 5) != 0, $urandom,
                     2'($urandom), 1'($urandom), m_wait && (($urandom % 3) == 0), $urandom);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule